// File: doc/BRIEF.md
# Exception Entry Controller

This block carries out exception and interrupt entry for a 32-bit processor core. Each cycle it looks at the pending exception causes, the external interrupt request and the global interrupt enable, and picks at most one cause by fixed priority. For the chosen cause it saves the current program counter into one of two link registers and updates the interrupt-enable bits. On the next clock edge it issues a one-cycle redirect carrying the handler address for the fetch stage.

There are two entry paths. Normal exceptions save into the exception-return register and the saved-exception enable bit. Debug exceptions (breakpoint, watchpoint) save into the breakpoint-return register and the saved-breakpoint enable bit. Handler slots are 32 bytes apart from a 256-byte-aligned base. Debug exceptions always use the debug base. A remap control bit moves normal exceptions onto the debug base as well. A system call that an external bypass path has already serviced does not take entry. It only moves the program counter past the call.

Software writes the interrupt-enable register through a write port. Exception entry takes precedence over that write when both occur in the same cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset is released, `redirect_vld` is 0, `ea_q` and `ba_q` are 0, and `ie_q` is 3'b000. In `ie_q`, bit 0 is the global enable, bit 1 is the saved-exception enable and bit 2 is the saved-breakpoint enable.
- R2: Cause codes are 0 reset, 1 breakpoint, 2 fetch bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 interrupt and 7 system call. Bit n of `pend_vec` requests cause n. When several causes are pending, the winner follows the order 0, 1, 3, 2, 4, 5, 7, 6 (first listed wins).
- R3: If a cause is selected in a cycle, `redirect_vld` is 1 for exactly the following cycle, with the winning code on `redirect_cause`. If no cause is selected, `redirect_vld` is 0 in the following cycle.
- R4: Normal entry (causes 2, 4, 5, 6, and cause 7 without bypass) loads `ea_q` with `cur_pc`, copies the global enable into the saved-exception enable, and clears the global enable. `ba_q` and the saved-breakpoint enable are unchanged.
- R5: The normal vector is {base[31:8], cause, 5'b00000}. The base is `base_dbg` when `dbg_remap` is 1 and `base_norm` otherwise. Bits [7:0] of either base have no effect.
- R6: Debug entry (causes 1, 3) loads `ba_q` with `cur_pc`, copies the global enable into the saved-breakpoint enable, and clears the global enable. It leaves `ea_q` and the saved-exception enable unchanged. It vectors to {base_dbg[31:8], cause, 5'b00000} whatever `dbg_remap` holds.
- R7: Cause 6 is taken only when `irq_req` is 1 and the global enable is 1 in that cycle. Bit 6 of `pend_vec` has no effect.
- R8: When cause 7 wins and `sc_bypass` is 1, the redirect address is `cur_pc` + 4, and `ea_q`, `ba_q` and `ie_q` are unchanged.
- R9: Reset-cause entry (cause 0) vectors to the normal-vector base selection with offset 0. It clears all three `ie_q` bits and leaves `ea_q` and `ba_q` unchanged.
- R10: With `ie_wr_en` high and no cause selected, `ie_q` takes `ie_wr_data` at the next edge. If a cause is selected in the same cycle, the write is dropped and the entry update applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_vec | input | 8 | Pending cause requests, bit n for cause n |
| irq_req | input | 1 | External interrupt request |
| sc_bypass | input | 1 | System call already serviced by bypass path |
| dbg_remap | input | 1 | Route normal exceptions through debug base |
| cur_pc | input | 32 | Program counter of the faulting or interrupted instruction |
| base_norm | input | 32 | Normal vector base |
| base_dbg | input | 32 | Debug vector base |
| ie_wr_en | input | 1 | Software write strobe for the enable register |
| ie_wr_data | input | 3 | Value written to the enable register |
| redirect_vld | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | New program counter |
| redirect_cause | output | 3 | Cause code of the entry taken |
| ea_q | output | 32 | Exception-return address register |
| ba_q | output | 32 | Breakpoint-return address register |
| ie_q | output | 3 | Enable register: bit 0 global, bit 1 saved-exception, bit 2 saved-breakpoint |

## Verification
A wrong priority choice or wrong path decode shows up one cycle after the stimulus, as a wrong `redirect_cause` or a wrong base in `redirect_pc`. The same error also leaves the wrong link register or the wrong saved-enable bit updated. A corrupted global enable may stay hidden until a later interrupt request is wrongly accepted or refused. For that reason the interrupt and enable-write scenarios are chained across several cycles. Each link register is compared after every step, so a stray write is caught in the cycle it happens.

// File: rtl/exc_entry_pkg.sv
// Package: shared constants and types for the exception entry controller.
// Assumes a fixed eight-code cause space; widths derive from it.
package exc_entry_pkg;

    localparam int CAUSE_W = 3;
    localparam int NCAUSE  = 1 << CAUSE_W;
    localparam int IE_W    = 3;

    // Bit positions inside the enable register.
    localparam int IE_GLB = 0;
    localparam int IE_EXC = 1;
    localparam int IE_BRK = 2;

    typedef enum logic [CAUSE_W-1:0] {
        CS_RESET  = 3'd0,
        CS_BRKPT  = 3'd1,
        CS_IBUS   = 3'd2,
        CS_WATCH  = 3'd3,
        CS_DBUS   = 3'd4,
        CS_DIVZ   = 3'd5,
        CS_IRQ    = 3'd6,
        CS_SCALL  = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        EK_RESET = 2'd0,
        EK_NORM  = 2'd1,
        EK_DEBUG = 2'd2,
        EK_SKIP  = 2'd3
    } entry_kind_e;

    typedef struct packed {
        logic        take;
        entry_kind_e kind;
        cause_e      cause;
    } entry_dec_t;

    // Priority order, highest first.
    localparam logic [CAUSE_W-1:0] PRIO_ORDER [NCAUSE] =
        '{3'd0, 3'd1, 3'd3, 3'd2, 3'd4, 3'd5, 3'd7, 3'd6};

endpackage

// File: rtl/exc_prio_sel.sv
// Module: exc_prio_sel
// Picks the winning cause among pending requests and classifies the entry
// path. Assumes pend_vec bit 6 is a placeholder: interrupt pending is built
// here from the request line gated by the global enable.
module exc_prio_sel
    import exc_entry_pkg::*;
(
    input  logic [NCAUSE-1:0] pend_vec,
    input  logic              irq_req,
    input  logic              glb_ie,
    input  logic              sc_bypass,
    output entry_dec_t        dec
);

    localparam logic [NCAUSE-1:0] IRQ_MASK = NCAUSE'(1) << CS_IRQ;

    logic [NCAUSE-1:0] eff_pend;
    logic              hit;
    logic [CAUSE_W-1:0] win;

    // Build effective pending set with interrupt gating.
    always_comb begin
        eff_pend = (pend_vec & ~IRQ_MASK)
                 | ((irq_req && glb_ie) ? IRQ_MASK : '0);
    end

    // Scan from lowest to highest priority so the highest one sticks.
    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int k = NCAUSE - 1; k >= 0; k--) begin
            if (eff_pend[PRIO_ORDER[k]]) begin
                hit = 1'b1;
                win = PRIO_ORDER[k];
            end
        end
    end

    // Classify the winner into an entry path.
    always_comb begin
        dec.take  = hit;
        dec.cause = cause_e'(win);
        unique case (cause_e'(win))
            CS_RESET:           dec.kind = EK_RESET;
            CS_BRKPT, CS_WATCH: dec.kind = EK_DEBUG;
            CS_SCALL:           dec.kind = sc_bypass ? EK_SKIP : EK_NORM;
            default:            dec.kind = EK_NORM;
        endcase
    end

endmodule

// File: rtl/exc_vec_gen.sv
// Module: exc_vec_gen
// Forms the new program counter for the selected entry. Assumes vector
// bases are aligned to the cause-slot field; their low bits are discarded.
module exc_vec_gen
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int SLOT_SHIFT = 5,
    parameter int STEP_BYTES = 4
) (
    input  entry_dec_t        dec,
    input  logic              dbg_remap,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   base_norm,
    input  logic [XLEN-1:0]   base_dbg,
    output logic [XLEN-1:0]   next_pc
);

    localparam int             ALIGN_BITS = SLOT_SHIFT + CAUSE_W;
    localparam logic [XLEN-1:0] LOW_MASK  = (XLEN'(1) << ALIGN_BITS) - 1;

    logic [XLEN-1:0] sel_base;
    logic [XLEN-1:0] slot_off;

    // Choose the base: debug path always uses debug base, others follow remap.
    always_comb begin
        if (dec.kind == EK_DEBUG || dbg_remap) sel_base = base_dbg & ~LOW_MASK;
        else                                   sel_base = base_norm & ~LOW_MASK;
    end

    // Slot offset is cause times slot size; reset lands on slot zero.
    always_comb begin
        slot_off = XLEN'(dec.cause) << SLOT_SHIFT;
    end

    // Final address: bypass steps over the call, otherwise base plus slot.
    always_comb begin
        if (dec.kind == EK_SKIP) next_pc = cur_pc + XLEN'(STEP_BYTES);
        else                     next_pc = sel_base | slot_off;
    end

endmodule

// File: rtl/exc_link_regs.sv
// Module: exc_link_regs
// Holds the two return-address registers and the enable register, and
// applies entry side effects. Assumes one entry at most per cycle; an entry
// overrides a same-cycle software write of the enable register.
module exc_link_regs
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  entry_dec_t       dec,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             ie_wr_en,
    input  logic [IE_W-1:0]  ie_wr_data,
    output logic [XLEN-1:0]  ea_q,
    output logic [XLEN-1:0]  ba_q,
    output logic [IE_W-1:0]  ie_q
);

    logic [IE_W-1:0] ie_d;

    // Capture return address on normal entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ea_q <= '0;
        else if (dec.take && dec.kind == EK_NORM) ea_q <= cur_pc;
    end

    // Capture return address on debug entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ba_q <= '0;
        else if (dec.take && dec.kind == EK_DEBUG) ba_q <= cur_pc;
    end

    // Next enable value: entry side effects first, then software write.
    always_comb begin
        ie_d = ie_q;
        if (dec.take) begin
            unique case (dec.kind)
                EK_RESET: ie_d = '0;
                EK_NORM: begin
                    ie_d[IE_EXC] = ie_q[IE_GLB];
                    ie_d[IE_GLB] = 1'b0;
                end
                EK_DEBUG: begin
                    ie_d[IE_BRK] = ie_q[IE_GLB];
                    ie_d[IE_GLB] = 1'b0;
                end
                default: ie_d = ie_q;
            endcase
        end else if (ie_wr_en) begin
            ie_d = ie_wr_data;
        end
    end

    // Enable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= '0;
        else        ie_q <= ie_d;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exc_entry_ctrl (top)
// Exception and interrupt entry for a 32-bit core: selects a cause, updates
// link and enable registers, and issues a registered one-cycle redirect.
// Assumes the caller holds a request only as long as it should be taken;
// every cycle with a selected cause produces one entry.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int SLOT_SHIFT = 5,
    parameter int STEP_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCAUSE-1:0]  pend_vec,
    input  logic               irq_req,
    input  logic               sc_bypass,
    input  logic               dbg_remap,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    base_norm,
    input  logic [XLEN-1:0]    base_dbg,
    input  logic               ie_wr_en,
    input  logic [IE_W-1:0]    ie_wr_data,
    output logic               redirect_vld,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [CAUSE_W-1:0] redirect_cause,
    output logic [XLEN-1:0]    ea_q,
    output logic [XLEN-1:0]    ba_q,
    output logic [IE_W-1:0]    ie_q
);

    entry_dec_t      dec;
    logic [XLEN-1:0] next_pc;

    exc_prio_sel u_sel (
        .pend_vec  (pend_vec),
        .irq_req   (irq_req),
        .glb_ie    (ie_q[IE_GLB]),
        .sc_bypass (sc_bypass),
        .dec       (dec)
    );

    exc_vec_gen #(
        .XLEN       (XLEN),
        .SLOT_SHIFT (SLOT_SHIFT),
        .STEP_BYTES (STEP_BYTES)
    ) u_vec (
        .dec       (dec),
        .dbg_remap (dbg_remap),
        .cur_pc    (cur_pc),
        .base_norm (base_norm),
        .base_dbg  (base_dbg),
        .next_pc   (next_pc)
    );

    exc_link_regs #(
        .XLEN (XLEN)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (dec),
        .cur_pc     (cur_pc),
        .ie_wr_en   (ie_wr_en),
        .ie_wr_data (ie_wr_data),
        .ea_q       (ea_q),
        .ba_q       (ba_q),
        .ie_q       (ie_q)
    );

    // Redirect pulse: set for the cycle after a selection.
    always_ff @(posedge clk) begin
        if (!rst_n) redirect_vld <= 1'b0;
        else        redirect_vld <= dec.take;
    end

    // Redirect payload, loaded only when an entry is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_pc    <= '0;
            redirect_cause <= '0;
        end else if (dec.take) begin
            redirect_pc    <= next_pc;
            redirect_cause <= dec.cause;
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Module: exc_entry_chk
// Port-level temporal checks for exc_entry_ctrl, bound to every instance.
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int SLOT_SHIFT = 5,
    parameter int STEP_BYTES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NCAUSE-1:0]  pend_vec,
    input logic               irq_req,
    input logic               sc_bypass,
    input logic               dbg_remap,
    input logic [XLEN-1:0]    cur_pc,
    input logic [XLEN-1:0]    base_norm,
    input logic [XLEN-1:0]    base_dbg,
    input logic               ie_wr_en,
    input logic [IE_W-1:0]    ie_wr_data,
    input logic               redirect_vld,
    input logic [XLEN-1:0]    redirect_pc,
    input logic [CAUSE_W-1:0] redirect_cause,
    input logic [XLEN-1:0]    ea_q,
    input logic [XLEN-1:0]    ba_q,
    input logic [IE_W-1:0]    ie_q
);

    localparam int            ALIGN_BITS = SLOT_SHIFT + CAUSE_W;
    localparam logic [NCAUSE-1:0] NO_IRQ = ~(NCAUSE'(1) << CS_IRQ);

    logic any_cause;
    assign any_cause = (|(pend_vec & NO_IRQ)) || (irq_req && ie_q[IE_GLB]);

    p_entry_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_cause |=> redirect_vld);

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cause |=> !redirect_vld);

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && redirect_cause == CS_IRQ) |-> $past(ie_q[IE_GLB]));

    p_normal_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && (redirect_cause == CS_IBUS || redirect_cause == CS_DBUS ||
                          redirect_cause == CS_DIVZ || redirect_cause == CS_IRQ ||
                          (redirect_cause == CS_SCALL && !$past(sc_bypass))))
        |-> (ea_q == $past(cur_pc) && ie_q[IE_EXC] == $past(ie_q[IE_GLB])
             && !ie_q[IE_GLB] && ba_q == $past(ba_q)));

    p_debug_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && (redirect_cause == CS_BRKPT || redirect_cause == CS_WATCH))
        |-> (redirect_pc[XLEN-1:ALIGN_BITS] == $past(base_dbg[XLEN-1:ALIGN_BITS])
             && ba_q == $past(cur_pc) && ie_q[IE_BRK] == $past(ie_q[IE_GLB])
             && !ie_q[IE_GLB] && ea_q == $past(ea_q)));

    p_bypass_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && redirect_cause == CS_SCALL && $past(sc_bypass))
        |-> (redirect_pc == $past(cur_pc) + XLEN'(STEP_BYTES)
             && ea_q == $past(ea_q) && ie_q == $past(ie_q)));

    p_slot_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && !(redirect_cause == CS_SCALL && $past(sc_bypass)))
        |-> (redirect_pc[ALIGN_BITS-1:0] ==
             (ALIGN_BITS'(redirect_cause) << SLOT_SHIFT)));

    p_reset_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && redirect_cause == CS_RESET) |-> (ie_q == '0));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN       (XLEN),
    .SLOT_SHIFT (SLOT_SHIFT),
    .STEP_BYTES (STEP_BYTES)
) u_exc_entry_chk (.*);

// File: tb/test_exc_entry_ctrl.sv
// Scoreboard bench: the driver pushes the expected outcome of each step,
// the monitor compares it one clock edge later.
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pend_vec = '0;
    logic        irq_req = 1'b0;
    logic        sc_bypass = 1'b0;
    logic        dbg_remap = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] base_norm = '0;
    logic [31:0] base_dbg = '0;
    logic        ie_wr_en = 1'b0;
    logic [2:0]  ie_wr_data = '0;
    logic        redirect_vld;
    logic [31:0] redirect_pc;
    logic [2:0]  redirect_cause;
    logic [31:0] ea_q, ba_q;
    logic [2:0]  ie_q;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (.*);

    typedef struct {
        logic        vld;
        logic [31:0] pc;
        logic [2:0]  cause;
        logic [31:0] ea;
        logic [31:0] ba;
        logic [2:0]  ie;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Bench model state, built from the requirements.
    logic [31:0] m_ea = '0, m_ba = '0;
    logic [2:0]  m_ie = '0;
    int          prio[8] = '{0, 1, 3, 2, 4, 5, 7, 6};

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] p, input logic i, input logic b,
                        input logic r, input logic [31:0] bn, input logic [31:0] bd,
                        input logic [31:0] pc, input logic we, input logic [2:0] wd,
                        input string tag);
        exp_t        e;
        logic [7:0]  eff;
        logic        take;
        int          c;
        logic [31:0] base;
        @(negedge clk);
        pend_vec = p; irq_req = i; sc_bypass = b; dbg_remap = r;
        base_norm = bn; base_dbg = bd; cur_pc = pc; ie_wr_en = we; ie_wr_data = wd;
        eff = p;
        eff[6] = i & m_ie[0];
        take = 1'b0;
        c = 0;
        for (int k = 0; k < 8; k++)
            if (!take && eff[prio[k]]) begin take = 1'b1; c = prio[k]; end
        base = r ? bd : bn;
        e.pc = '0;
        if (take) begin
            if (c == 0) begin
                e.pc = {base[31:8], 8'h00};
                m_ie = 3'b000;
            end else if (c == 1 || c == 3) begin
                e.pc = {bd[31:8], 3'(c), 5'b0};
                m_ba = pc;
                m_ie[2] = m_ie[0];
                m_ie[0] = 1'b0;
            end else if (c == 7 && b) begin
                e.pc = pc + 32'd4;
            end else begin
                e.pc = {base[31:8], 3'(c), 5'b0};
                m_ea = pc;
                m_ie[1] = m_ie[0];
                m_ie[0] = 1'b0;
            end
        end else if (we) begin
            m_ie = wd;
        end
        e.vld = take; e.cause = 3'(c);
        e.ea = m_ea; e.ba = m_ba; e.ie = m_ie; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(8'h00, 1'b0, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000,
             32'h0, 1'b0, 3'b000, tag);
    endtask

    task automatic wr_ie(input logic [2:0] v, input string tag);
        step(8'h00, 1'b0, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000,
             32'h0, 1'b1, v, tag);
    endtask

    // Monitor: compare one expected item shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(redirect_vld == e.vld, e.tag, "redirect_vld",
                  32'(redirect_vld), 32'(e.vld));
            if (e.vld) begin
                check(redirect_pc == e.pc, e.tag, "redirect_pc", redirect_pc, e.pc);
                check(redirect_cause == e.cause, e.tag, "redirect_cause",
                      32'(redirect_cause), 32'(e.cause));
            end
            check(ea_q == e.ea, e.tag, "ea_q", ea_q, e.ea);
            check(ba_q == e.ba, e.tag, "ba_q", ba_q, e.ba);
            check(ie_q == e.ie, e.tag, "ie_q", 32'(ie_q), 32'(e.ie));
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state observed while reset is held.
        check(redirect_vld == 1'b0, "R1", "redirect_vld", 32'(redirect_vld), 0);
        check(ea_q == '0, "R1", "ea_q", ea_q, 0);
        check(ba_q == '0, "R1", "ba_q", ba_q, 0);
        check(ie_q == '0, "R1", "ie_q", 32'(ie_q), 0);
        rst_n = 1'b1;
        idle("R1 R3 idle after reset");
        // R7: bit 6 of pend_vec and an ungated request do nothing.
        step(8'h40, 1'b0, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h100,
             1'b0, 3'b0, "R7 pend bit6 ignored");
        step(8'h00, 1'b1, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h104,
             1'b0, 3'b0, "R7 irq with global enable off");
        wr_ie(3'b001, "R10 enable write");
        step(8'h00, 1'b1, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h1000,
             1'b0, 3'b0, "R4 R5 R7 irq taken");
        wr_ie(3'b001, "R10 re-enable");
        step(8'h04, 1'b0, 1'b0, 1'b1, 32'h4000_0055, 32'h8000_0000, 32'h1100,
             1'b0, 3'b0, "R5 fetch error remapped");
        step(8'h20, 1'b0, 1'b0, 1'b0, 32'h1234_56AB, 32'h8000_0000, 32'h1200,
             1'b0, 3'b0, "R4 R5 divide by zero, base low bits");
        wr_ie(3'b001, "R10 re-enable");
        step(8'h02, 1'b0, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h1300,
             1'b0, 3'b0, "R6 breakpoint no remap");
        wr_ie(3'b011, "R10 enable write two bits");
        step(8'h08, 1'b0, 1'b0, 1'b1, 32'h4000_0000, 32'h9000_00F0, 32'h1400,
             1'b0, 3'b0, "R6 watchpoint");
        step(8'h2C, 1'b0, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h1500,
             1'b0, 3'b0, "R2 debug over bus error");
        step(8'hB4, 1'b0, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h1600,
             1'b0, 3'b0, "R2 fetch error first");
        step(8'hA0, 1'b0, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h1700,
             1'b0, 3'b0, "R2 divide over system call");
        wr_ie(3'b001, "R10 re-enable");
        step(8'h80, 1'b1, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h1800,
             1'b0, 3'b0, "R2 R4 system call over irq");
        step(8'h80, 1'b0, 1'b1, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h2000,
             1'b0, 3'b0, "R8 bypassed system call");
        step(8'h90, 1'b0, 1'b1, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h2100,
             1'b0, 3'b0, "R2 R8 bus error beats bypass");
        wr_ie(3'b111, "R10 enable write all");
        step(8'h03, 1'b0, 1'b0, 1'b1, 32'h4000_0000, 32'hA000_0033, 32'h2200,
             1'b0, 3'b0, "R9 reset cause");
        wr_ie(3'b001, "R10 re-enable");
        step(8'h10, 1'b0, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h2300,
             1'b1, 3'b111, "R10 entry beats write");
        step(8'h00, 1'b1, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 32'h2400,
             1'b0, 3'b0, "R7 irq refused after entry");
        idle("R3 final idle");
        repeat (3) @(posedge clk);
        #2;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule